// File: doc/BRIEF.md
# Transmit Word-Clock Phase Aligner

This block carries 10-bit transmit words from several lanes, each clocked by its own returned word clock, into one internal word-clock domain. The returned clocks run at exactly the internal clock's frequency. Their phase against it is unknown but fixed. Each lane has a small dual-clock buffer. Its write pointer crosses into the internal domain as a Gray code through two flops.

The read pointer is set once, while the block comes out of reset. It is placed so that the synchronized write-to-read separation sits in the middle of the safe window. After that, the read side advances once per internal cycle and never consults the write side for flow control. Bounded phase wander therefore shifts the separation by a word at most, and no word is lost or repeated.

If a lane's separation leaves the window, a per-lane flag rises and stays set until the next reset. While reset is asserted, every lane outputs the all-zero idle word and its flag is held low.

Top module: `txPhaseAligner`

## Requirements
- R1: Each lane g writes on `laneClk[g]` and delivers on `sysClk`. Lane g uses bits [g*WIDTH +: WIDTH] of both `laneData` and `txWord`, and lanes do not interact.
- R2: While `rstIn` is high, `txWord` is all zeros and `alignErr` is all zeros.
- R3: After `rstIn` falls, each lane outputs zero until its first data word. That word appears after the (SETTLE+3)-th rising `sysClk` edge following the release. From then on, words leave in the order they were written, one per cycle, with no gap and no repeat.
- R4: At the end of alignment, the read pointer is loaded so that the synchronized separation equals (DEPTH-2)/2. A lane whose clock gains or loses one cycle, or wanders by less than one word period, keeps continuous data and no error.
- R5: `alignErr[g]` rises when lane g's synchronized separation becomes 0 or exceeds DEPTH-3. Losing four write cycles or gaining four write cycles triggers it.
- R6: A raised `alignErr[g]` stays high until `rstIn` is asserted, even after the lane's clock returns to its original phase.
- R7: An error in one lane leaves the other lanes' flags low and their data continuous.
- R8: Asserting `rstIn` again clears all flags and re-centres every lane. After the new release, R3 holds again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Internal word clock shared by all lanes |
| rstIn | input | 1 | Asynchronous active-high reset; alignment happens on its release |
| laneClk | input | LANES | Returned word clock of each lane |
| laneData | input | LANES*WIDTH | Words written by each lane on its own clock |
| txWord | output | LANES*WIDTH | Words delivered on sysClk, zero while idle |
| alignErr | output | LANES | Sticky per-lane window violation flag |

## Verification
The bench builds the block with four lanes, 10-bit words, eight buffer entries and an eight-cycle settle time. Each lane clock gets its own fractional-nanosecond phase, so every synchronized separation and timing value can be computed exactly in the bench.

Each lane writes a running count tagged with its lane number. This makes any lost, repeated or misrouted word visible at the output. The lane clocks can be stretched, paused or sped up for a chosen number of cycles. That puts the one-cycle boundary of the window, and the four-cycle violations on both sides, within reach on chosen lanes while the others keep running.

// File: rtl/txpa_pkg.sv
`timescale 1ns/1ps
package txpa_pkg;

  typedef enum logic {
    PH_ALIGN = 1'b0,
    PH_RUN   = 1'b1
  } alignPhase_t;

  // strobes from lane control to lane datapath (read domain)
  typedef struct packed {
    logic loadPtr;  // overwrite read pointer with loadVal
    logic advance;  // step read pointer by one
    logic emit;     // present the addressed entry instead of idle
  } rdStrobe_t;

endpackage

// File: rtl/txpaRstSync.sv
`timescale 1ns/1ps
module txpaRstSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstAsync,
  output logic rstSync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) chain <= '1;
    else          chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rstSync = chain[STAGES-1];
endmodule

// File: rtl/txpaLaneData.sv
`timescale 1ns/1ps
module txpaLaneData
  import txpa_pkg::*;
#(
  parameter  int WIDTH = 10,
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic             wrClk,
  input  logic             wrRst,
  input  logic [WIDTH-1:0] wrData,
  output logic [PW-1:0]    wrPtrGray,
  input  logic             rdClk,
  input  logic             rdRst,
  input  rdStrobe_t        strobe,
  input  logic [PW-1:0]    loadVal,
  output logic [PW-1:0]    rdPtr,
  output logic [WIDTH-1:0] rdWord
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrBin;
  logic [PW-1:0]    wrBinNext;

  assign wrBinNext = wrBin + PW'(1);

  // write domain: binary pointer plus registered Gray copy
  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrBin     <= '0;
      wrPtrGray <= '0;
    end else begin
      wrBin     <= wrBinNext;
      wrPtrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  always_ff @(posedge wrClk) begin
    if (!wrRst) mem[wrBin[AW-1:0]] <= wrData;
  end

  // read domain
  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      rdPtr  <= '0;
      rdWord <= '0;
    end else begin
      if (strobe.loadPtr)      rdPtr <= loadVal;
      else if (strobe.advance) rdPtr <= rdPtr + PW'(1);
      rdWord <= strobe.emit ? mem[rdPtr[AW-1:0]] : '0;
    end
  end
endmodule

// File: rtl/txpaLaneCtrl.sv
`timescale 1ns/1ps
module txpaLaneCtrl
  import txpa_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int SETTLE = 8,
  localparam int PW     = $clog2(DEPTH) + 1,
  localparam int CW     = $clog2(SETTLE) + 1,
  localparam int CENTER = (DEPTH - 2) / 2,
  localparam int UPPER  = DEPTH - 3
) (
  input  logic          rdClk,
  input  logic          rdRst,
  input  logic [PW-1:0] wrPtrGray,
  input  logic [PW-1:0] rdPtr,
  output rdStrobe_t     strobe,
  output logic [PW-1:0] loadVal,
  output logic          alignErr
);
  logic [PW-1:0] syncA, syncB, syncBin, sep;
  logic [CW-1:0] settleCnt;
  alignPhase_t   phase;
  logic          outOfWindow;

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= wrPtrGray;
      syncB <= syncA;
    end
  end

  always_comb begin
    syncBin[PW-1] = syncB[PW-1];
    for (int i = PW - 2; i >= 0; i--) syncBin[i] = syncBin[i+1] ^ syncB[i];
  end

  assign sep         = syncBin - rdPtr;
  assign outOfWindow = (sep == '0) || (sep > PW'(UPPER));
  // synchronized pointer advances by one before the loaded value is used
  assign loadVal     = syncBin + PW'(1) - PW'(CENTER);

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      phase     <= PH_ALIGN;
      settleCnt <= '0;
    end else if (phase == PH_ALIGN) begin
      if (settleCnt == CW'(SETTLE - 1)) phase <= PH_RUN;
      else                              settleCnt <= settleCnt + CW'(1);
    end
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst)                            alignErr <= 1'b0;
    else if (phase == PH_RUN && outOfWindow) alignErr <= 1'b1;
  end

  always_comb begin
    strobe.loadPtr = (phase == PH_ALIGN);
    strobe.advance = (phase == PH_RUN);
    strobe.emit    = (phase == PH_RUN);
  end
endmodule

// File: rtl/txPhaseAligner.sv
`timescale 1ns/1ps
module txPhaseAligner
  import txpa_pkg::*;
#(
  parameter  int LANES  = 4,
  parameter  int WIDTH  = 10,
  parameter  int DEPTH  = 8,
  parameter  int SETTLE = 8,
  localparam int PW     = $clog2(DEPTH) + 1
) (
  input  logic                   sysClk,
  input  logic                   rstIn,
  input  logic [LANES-1:0]       laneClk,
  input  logic [LANES*WIDTH-1:0] laneData,
  output logic [LANES*WIDTH-1:0] txWord,
  output logic [LANES-1:0]       alignErr
);
  logic sysRst;

  txpaRstSync #(.STAGES(2)) sysRstSync (
    .clk(sysClk), .rstAsync(rstIn), .rstSync(sysRst)
  );

  for (genvar g = 0; g < LANES; g++) begin : laneG
    logic          wrRst;
    logic [PW-1:0] wrPtrGray, rdPtr, loadVal;
    rdStrobe_t     strobe;

    txpaRstSync #(.STAGES(2)) wrRstSync (
      .clk(laneClk[g]), .rstAsync(rstIn), .rstSync(wrRst)
    );

    txpaLaneData #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp (
      .wrClk(laneClk[g]), .wrRst(wrRst), .wrData(laneData[g*WIDTH +: WIDTH]),
      .wrPtrGray(wrPtrGray),
      .rdClk(sysClk), .rdRst(sysRst), .strobe(strobe), .loadVal(loadVal),
      .rdPtr(rdPtr), .rdWord(txWord[g*WIDTH +: WIDTH])
    );

    txpaLaneCtrl #(.DEPTH(DEPTH), .SETTLE(SETTLE)) ctl (
      .rdClk(sysClk), .rdRst(sysRst), .wrPtrGray(wrPtrGray), .rdPtr(rdPtr),
      .strobe(strobe), .loadVal(loadVal), .alignErr(alignErr[g])
    );
  end
endmodule

// File: rtl/txPhaseAlignerChk.sv
`timescale 1ns/1ps
module txPhaseAlignerChk #(
  parameter  int LANES  = 4,
  parameter  int WIDTH  = 10,
  parameter  int SETTLE = 8,
  localparam int SW     = $clog2(SETTLE + 6) + 1
) (
  input logic                   sysClk,
  input logic                   rstIn,
  input logic [LANES*WIDTH-1:0] txWord,
  input logic [LANES-1:0]       alignErr
);
  logic [SW-1:0] sinceRst;

  always_ff @(posedge sysClk or posedge rstIn) begin
    if (rstIn)                               sinceRst <= '0;
    else if (sinceRst != SW'(SETTLE + 5))    sinceRst <= sinceRst + SW'(1);
  end

  // R2
  idle_in_reset_chk: assert property (@(posedge sysClk)
    rstIn |-> (txWord == '0 && alignErr == '0));

  // R3
  quiet_after_release_chk: assert property (@(posedge sysClk) disable iff (rstIn)
    (sinceRst < SW'(SETTLE)) |-> (txWord == '0));

  // R5
  no_early_err_chk: assert property (@(posedge sysClk) disable iff (rstIn)
    (sinceRst < SW'(SETTLE)) |-> (alignErr == '0));

  // R6
  err_sticky_chk: assert property (@(posedge sysClk) disable iff (rstIn)
    (alignErr != '0) |=> ((alignErr & $past(alignErr)) == $past(alignErr)));
endmodule

bind txPhaseAligner txPhaseAlignerChk #(.LANES(LANES), .WIDTH(WIDTH), .SETTLE(SETTLE)) chk (
  .sysClk(sysClk), .rstIn(rstIn), .txWord(txWord), .alignErr(alignErr)
);

// File: tb/txPhaseAligner_test.sv
`timescale 1ns/1ps
module txPhaseAligner_test;
  localparam int L = 4;
  localparam int W = 10;
  localparam int D = 8;
  localparam int S = 8;

  logic           sysClk = 1'b0;
  logic           rstIn  = 1'b1;
  logic [L-1:0]   laneClk;
  logic [L*W-1:0] laneData;
  logic [L*W-1:0] txWord;
  logic [L-1:0]   alignErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // lane clock control
  int  dropCnt[L];
  int  addCnt[L];
  int  adjCnt[L];
  real adjNs[L];
  logic [7:0] laneCnt[L];

  // output monitor state
  bit         monEn = 1'b0;
  int         cyc = 0;
  bit         started[L];
  logic [W-1:0] prevW[L];
  int         breaks[L];
  int         seen[L];
  int         firstAt[L];
  int         badId[L];

  txPhaseAligner #(.LANES(L), .WIDTH(W), .DEPTH(D), .SETTLE(S)) uut (
    .sysClk(sysClk), .rstIn(rstIn), .laneClk(laneClk), .laneData(laneData),
    .txWord(txWord), .alignErr(alignErr)
  );

  always #2 sysClk = ~sysClk;

  for (genvar g = 0; g < L; g++) begin : laneGen
    initial begin
      laneClk[g] = 1'b0;
      laneCnt[g] = 8'd1;
      dropCnt[g] = 0; addCnt[g] = 0; adjCnt[g] = 0; adjNs[g] = 0.0;
      #(0.5 + 0.9 * g);
      forever begin
        if (dropCnt[g] > 0) begin
          dropCnt[g]--;
          #4;
        end else if (addCnt[g] > 0) begin
          addCnt[g]--;
          laneClk[g] = 1'b1; #1;
          laneClk[g] = 1'b0; #1;
        end else begin
          laneClk[g] = 1'b1; #2;
          laneClk[g] = 1'b0;
          if (adjCnt[g] > 0) begin
            adjCnt[g]--;
            #(2.0 + adjNs[g]);
          end else begin
            #2;
          end
        end
      end
    end
    always @(negedge laneClk[g]) laneCnt[g] <= laneCnt[g] + 8'd1;
    assign laneData[g*W +: W] = {2'(g), laneCnt[g]};
  end

  always @(negedge sysClk) begin
    if (monEn) begin
      cyc++;
      for (int g = 0; g < L; g++) begin
        logic [W-1:0] w;
        logic [W-1:0] e;
        w = txWord[g*W +: W];
        if (!started[g]) begin
          if (w != '0) begin
            started[g] = 1'b1;
            firstAt[g] = cyc;
            prevW[g]   = w;
            if (w[9:8] != 2'(g)) badId[g]++;
          end
        end else begin
          e = {2'(g), 8'(prevW[g][7:0] + 8'd1)};
          if (w != e) breaks[g]++;
          prevW[g] = w;
          seen[g]++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge sysClk);
    #1;
  endtask

  task automatic clearMon();
    for (int g = 0; g < L; g++) begin
      started[g] = 1'b0; prevW[g] = '0; breaks[g] = 0;
      seen[g] = 0; firstAt[g] = -1; badId[g] = 0;
    end
    cyc = 0;
  endtask

  // R2 / R8: reset hold, idle outputs, flags low, then release
  task automatic resetPhase(input string req, input int n);
    monEn = 1'b0;
    rstIn = 1'b1;
    waitCyc(2);
    for (int g = 0; g < L; g++) begin
      check(txWord[g*W +: W] == '0, req, $sformatf("lane %0d idle word in reset", g),
            int'(txWord[g*W +: W]), 0);
      check(alignErr[g] == 1'b0, req, $sformatf("lane %0d flag low in reset", g),
            int'(alignErr[g]), 0);
    end
    waitCyc(n);
    clearMon();
    monEn = 1'b1;
    rstIn = 1'b0;
  endtask

  task automatic startupChecks(input string req);
    for (int g = 0; g < L; g++) begin
      // R3: first word after the (S+3)-th edge; lane 0 may carry one zero word first
      check(firstAt[g] >= S + 3 && firstAt[g] <= S + 4, req,
            $sformatf("lane %0d first data cycle", g), firstAt[g], S + 3);
      // R1: lane tag in upper bits of its own slice
      check(badId[g] == 0, "R1", $sformatf("lane %0d tag in first word", g), badId[g], 0);
    end
  endtask

  task automatic cleanChecks(input string req, input int lo, input int hi, input int minSeen);
    for (int g = lo; g <= hi; g++) begin
      check(breaks[g] == 0, req, $sformatf("lane %0d order breaks", g), breaks[g], 0);
      check(seen[g] >= minSeen, req, $sformatf("lane %0d words delivered", g), seen[g], minSeen);
      check(alignErr[g] == 1'b0, req, $sformatf("lane %0d flag", g), int'(alignErr[g]), 0);
    end
  endtask

  initial begin
    clearMon();
    waitCyc(1);
    check(txWord == '0 && alignErr == '0, "R2", "outputs at start", int'(alignErr), 0);

    // R2, R3, R1: first alignment
    resetPhase("R2", 10);
    waitCyc(300);
    startupChecks("R3");
    cleanChecks("R3", 0, L - 1, 280);

    // R4: phase wander of +3 ns then back on every lane
    for (int g = 0; g < L; g++) begin adjNs[g] = 1.0; adjCnt[g] = 3; end
    waitCyc(100);
    for (int g = 0; g < L; g++) begin adjNs[g] = -1.0; adjCnt[g] = 3; end
    waitCyc(100);
    cleanChecks("R4", 0, L - 1, 480);

    // R4 boundary: lane 0 loses one cycle, lane 1 gains one cycle
    dropCnt[0] = 1;
    addCnt[1]  = 2;
    waitCyc(100);
    cleanChecks("R4", 0, 1, 570);

    // R5 / R7: lane 2 loses four cycles, lane 3 gains four
    dropCnt[2] = 4;
    addCnt[3]  = 8;
    waitCyc(50);
    check(alignErr[2] == 1'b1, "R5", "lane 2 underrun flag", int'(alignErr[2]), 1);
    check(alignErr[3] == 1'b1, "R5", "lane 3 overrun flag", int'(alignErr[3]), 1);
    cleanChecks("R7", 0, 1, 620);

    // R6: restore lanes 2 and 3, flags stay up
    addCnt[2]  = 8;
    dropCnt[3] = 4;
    waitCyc(60);
    check(alignErr[3:2] == 2'b11, "R6", "flags held after recovery", int'(alignErr[3:2]), 3);
    check(alignErr[1:0] == 2'b00, "R7", "other lanes unaffected", int'(alignErr[1:0]), 0);

    // R8: reset clears and re-centres every lane
    resetPhase("R8", 5);
    waitCyc(300);
    startupChecks("R8");
    cleanChecks("R8", 0, L - 1, 280);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule